// File: doc/BRIEF.md
# Two-Frame Slip-Controlled Receive Elastic Store

This block sits on the receive path between a line-rate framer and a system backplane. The two sides run on unrelated clocks. The line side writes recovered payload one channel byte per strobe, and marks the first channel of each frame. The backplane side asks for timeslots with its own clock and frame pulse. The store holds exactly two frames in two banks. Only the count of completed frames crosses into the read domain. It crosses as a two-bit Gray code through a two-flop synchronizer.

Each read frame pulse is a decision point. If no new frame has completed since the last decision, the previous frame is played again in full. If two or more have completed, the reader jumps to the newest complete frame and the older ones are lost. Both cases are whole-frame slips, and both are reported with their kind. In the 24-channel mode, the line frame is spread over a 32-slot backplane frame. Every fourth slot is idle. Slot 0 can optionally carry the line frame's F-bit. A minimum-delay mode reads the bank that is being written, for pass-through use when the two sides are frame-aligned.

Top module: `rx_elastic_store`

## Requirements
- R1: A written frame is read back in full and in order at the next read frame pulse. In 32-channel mode (`t1_mode`=0), slot s returns channel s, and `fbit_pass` has no effect.
- R2: When no new frame has completed since the previous decision, the previous frame is output again in full. `slip_evt` pulses and `slip_del` reads 0.
- R3: When two or more frames have completed since the previous decision, the newest complete frame is output. `slip_evt` pulses and `slip_del` reads 1. After any decision in normal mode, at most one complete frame is left unread.
- R4: A slip is decided only at a read frame pulse (`r_fp` with `r_en`). `slip_evt` is high for the one cycle after that edge. `slip_del` keeps its value until the next slip.
- R5: Until the first complete frame has been taken, every read returns 8'hFF and no slip is reported.
- R6: With `t1_mode`=1, a slot s with s mod 4 = 0 returns 8'hFF. Any other slot returns line channel s - s/4 - 1, where channels are numbered 0 to 23.
- R7: With `t1_mode`=1 and `fbit_pass`=1, slot 0 returns {F, 7'h7F}. F is the value of `w_fbit` sampled with `w_sof` for that frame.
- R8: With `min_delay`=1, the frame pulse selects the bank currently being written, so bytes already written in the frame in progress are read back. No slip is reported.
- R9: `r_data` is registered, and returns the byte for a slot on the `rclk` cycle after the `r_en` edge. Reset gives `r_data`=8'hFF, `slip_evt`=0 and `slip_del`=0.
- R10: The synchronized completed-frame count changes by at most one Gray bit per read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side clock |
| wrst | input | 1 | Line-side synchronous reset, active high |
| w_en | input | 1 | Write strobe for one channel byte |
| w_sof | input | 1 | With `w_en`: this byte is channel 0 of a new frame |
| w_fbit | input | 1 | Frame's F-bit, sampled with `w_sof` |
| w_data | input | 8 | Channel byte |
| rclk | input | 1 | Backplane clock |
| rrst | input | 1 | Backplane synchronous reset, active high |
| r_fp | input | 1 | With `r_en`: this request is slot 0 and a decision point |
| r_en | input | 1 | Request for the next slot |
| t1_mode | input | 1 | 1: 24-channel line frame mapped to 32 slots; 0: 32 channels |
| fbit_pass | input | 1 | Put the F-bit in slot 0 in 24-channel mode |
| min_delay | input | 1 | Read the bank being written; no slip control |
| r_data | output | 8 | Slot byte, one cycle after the request |
| slip_evt | output | 1 | One-cycle pulse after a slip decision |
| slip_del | output | 1 | Kind of last slip: 1 deleted, 0 repeated |

## Verification
The bench drives frame counts of 0, 1, 2 and 3 between read frames. This covers repeat, sequential read and both delete depths, including a count that wraps the two-bit pointer. A reader that repeated part of a frame, or jumped to the oldest frame instead of the newest, would return bytes from the wrong base. A reader that got the wrap wrong would mistake three pending frames for none. The unprimed case catches a design that plays uninitialised banks or flags a slip before any data exists. The 24-channel frames check idle-slot placement, the per-frame F-bit capture with `fbit_pass` on and off, and a channel offset that is off by one. The minimum-delay read checks that the bank being written is chosen, not the completed one.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int FCW = 2;  // completed-frame counter width (two banks plus wrap bit)

  function automatic logic [FCW-1:0] bin2gray(input logic [FCW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [FCW-1:0] gray2bin(input logic [FCW-1:0] g);
    logic [FCW-1:0] b;
    b[FCW-1] = g[FCW-1];
    for (int i = FCW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/es_sync.sv
module es_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl
  import es_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int T1_CH = 24,
  localparam int SW = $clog2(SLOTS),
  localparam int AW = SW + 1
) (
  input  logic           wclk,
  input  logic           wrst,
  input  logic           w_en,
  input  logic           w_sof,
  input  logic           t1_mode,
  output logic           ram_we,
  output logic [AW-1:0]  ram_waddr,
  output logic           fb_we,
  output logic           fb_bank,
  output logic [FCW-1:0] wdone_gray
);
  logic [SW-1:0]  wch;
  logic [SW-1:0]  ch_now;
  logic [SW-1:0]  last_ch;
  logic [FCW-1:0] wdone;

  always_comb begin
    ch_now    = w_sof ? '0 : wch;
    last_ch   = t1_mode ? SW'(T1_CH - 1) : SW'(SLOTS - 1);
    ram_we    = w_en;
    ram_waddr = {wdone[0], ch_now};
    fb_we     = w_en && w_sof;
    fb_bank   = wdone[0];
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wch        <= '0;
      wdone      <= '0;
      wdone_gray <= '0;
    end else begin
      wdone_gray <= bin2gray(wdone);
      if (w_en) begin
        if (ch_now >= last_ch) begin
          wch   <= '0;
          wdone <= wdone + 1'b1;
        end else begin
          wch <= ch_now + 1'b1;
        end
      end
    end
  end

  // R10: the published count moves one Gray step at a time
  assert_gray_src_R10: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wdone_gray ^ $past(wdone_gray)) <= 1);
endmodule

// File: rtl/es_ram.sv
module es_ram #(
  parameter int DW = 8,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          fb_we,
  input  logic          fb_bank,
  input  logic          fb_val,
  output logic [1:0]    fb_q,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          ovr_en,
  input  logic [DW-1:0] ovr_val,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) fb_q <= '0;
    else if (fb_we) fb_q[fb_bank] <= fb_val;
  end

  always_ff @(posedge rclk) begin
    if (rrst) rdata <= '1;
    else if (re) rdata <= ovr_en ? ovr_val : mem[raddr];
  end
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
  import es_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int T1_CH = 24,
  localparam int SW = $clog2(SLOTS),
  localparam int AW = SW + 1,
  localparam int GROUP = SLOTS / (SLOTS - T1_CH)
) (
  input  logic           rclk,
  input  logic           rrst,
  input  logic           r_fp,
  input  logic           r_en,
  input  logic           t1_mode,
  input  logic           fbit_pass,
  input  logic           min_delay,
  input  logic [FCW-1:0] wdone_s,
  output logic [AW-1:0]  raddr,
  output logic           ovr_en,
  output logic           ovr_fbit,
  output logic           cur_bank,
  output logic           slip_evt,
  output logic           slip_del
);
  logic [FCW-1:0] rptr, avail, d_ptr;
  logic           rbank, live, primed;
  logic [SW-1:0]  rslot, slot, ch;
  logic           d_bank, d_live, d_slip, d_del, cur_live, idle_slot;

  always_comb begin
    avail  = wdone_s - rptr;
    slot   = r_fp ? '0 : rslot;
    d_bank = rptr[0];
    d_ptr  = rptr;
    d_live = 1'b1;
    d_slip = 1'b0;
    d_del  = 1'b0;
    if (min_delay) begin
      d_bank = wdone_s[0];
      d_ptr  = wdone_s;
    end else if (avail == '0) begin
      d_bank = ~rptr[0];
      d_live = primed;
      d_slip = primed;
    end else if (avail == FCW'(1)) begin
      d_ptr = rptr + 1'b1;
    end else begin
      d_bank = ~wdone_s[0];
      d_ptr  = wdone_s;
      d_slip = primed;
      d_del  = 1'b1;
    end
    cur_bank = r_fp ? d_bank : rbank;
    cur_live = r_fp ? d_live : live;
    if (t1_mode) begin
      idle_slot = (slot % SW'(GROUP)) == '0;
      ch        = slot - (slot / SW'(GROUP)) - SW'(1);
    end else begin
      idle_slot = 1'b0;
      ch        = slot;
    end
    ovr_fbit = cur_live && t1_mode && fbit_pass && (slot == '0);
    ovr_en   = !cur_live || idle_slot;
    raddr    = {cur_bank, ch};
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr     <= '0;
      rbank    <= 1'b0;
      live     <= 1'b0;
      primed   <= 1'b0;
      rslot    <= '0;
      slip_evt <= 1'b0;
      slip_del <= 1'b0;
    end else begin
      slip_evt <= 1'b0;
      if (r_en) rslot <= slot + 1'b1;
      if (r_en && r_fp) begin
        rbank  <= d_bank;
        rptr   <= d_ptr;
        live   <= d_live;
        primed <= primed | d_live;
        if (d_slip) begin
          slip_evt <= 1'b1;
          slip_del <= d_del;
        end
      end
    end
  end

  // R4: a slip report only follows a frame-pulse request
  assert_slip_at_fp_R4: assert property (@(posedge rclk) disable iff (rrst)
    slip_evt |-> $past(r_en && r_fp));
  // R8: no slip control in minimum-delay mode
  assert_min_no_slip_R8: assert property (@(posedge rclk) disable iff (rrst)
    $past(min_delay) |-> !slip_evt);
  // R3: after a normal-mode decision no backlog beyond one frame remains
  assert_no_backlog_R3: assert property (@(posedge rclk) disable iff (rrst)
    $past(r_en && r_fp && !min_delay) |-> avail <= FCW'(1));
  // R6: data slots in 24-channel mode address only real channels
  assert_map_range_R6: assert property (@(posedge rclk) disable iff (rrst)
    (r_en && t1_mode && !ovr_en) |-> ch < SW'(T1_CH));
endmodule

// File: rtl/rx_elastic_store.sv
module rx_elastic_store
  import es_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int T1_CH = 24,
  parameter int DW    = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int AW = SW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          w_en,
  input  logic          w_sof,
  input  logic          w_fbit,
  input  logic [DW-1:0] w_data,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          r_fp,
  input  logic          r_en,
  input  logic          t1_mode,
  input  logic          fbit_pass,
  input  logic          min_delay,
  output logic [DW-1:0] r_data,
  output logic          slip_evt,
  output logic          slip_del
);
  logic           ram_we, fb_we, fb_bank, ovr_en, ovr_fbit, cur_bank;
  logic [AW-1:0]  waddr, raddr;
  logic [FCW-1:0] wdone_gray, gray_sync, wdone_s;
  logic [1:0]     fb_q;
  logic [DW-1:0]  ovr_val;

  es_wr_ctrl #(.SLOTS(SLOTS), .T1_CH(T1_CH)) u_wr (
    .wclk(wclk), .wrst(wrst), .w_en(w_en), .w_sof(w_sof), .t1_mode(t1_mode),
    .ram_we(ram_we), .ram_waddr(waddr), .fb_we(fb_we), .fb_bank(fb_bank),
    .wdone_gray(wdone_gray));

  es_sync #(.W(FCW)) u_sync (
    .clk(rclk), .rst(rrst), .d(wdone_gray), .q(gray_sync));

  assign wdone_s = gray2bin(gray_sync);

  es_rd_ctrl #(.SLOTS(SLOTS), .T1_CH(T1_CH)) u_rd (
    .rclk(rclk), .rrst(rrst), .r_fp(r_fp), .r_en(r_en), .t1_mode(t1_mode),
    .fbit_pass(fbit_pass), .min_delay(min_delay), .wdone_s(wdone_s),
    .raddr(raddr), .ovr_en(ovr_en), .ovr_fbit(ovr_fbit), .cur_bank(cur_bank),
    .slip_evt(slip_evt), .slip_del(slip_del));

  assign ovr_val = ovr_fbit ? {fb_q[cur_bank], {(DW-1){1'b1}}} : '1;

  es_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .wrst(wrst), .we(ram_we), .waddr(waddr), .wdata(w_data),
    .fb_we(fb_we), .fb_bank(fb_bank), .fb_val(w_fbit), .fb_q(fb_q),
    .rclk(rclk), .rrst(rrst), .re(r_en), .raddr(raddr), .ovr_en(ovr_en),
    .ovr_val(ovr_val), .rdata(r_data));

  // R10: the synchronized count never jumps more than one Gray step
  assert_gray_sync_R10: assert property (@(posedge rclk) disable iff (rrst)
    $countones(gray_sync ^ $past(gray_sync)) <= 1);
endmodule

// File: tb/test_rx_elastic_store.sv
module test_rx_elastic_store;
  logic wclk = 0, rclk = 0;
  logic wrst = 1, rrst = 1;
  logic w_en = 0, w_sof = 0, w_fbit = 0;
  logic [7:0] w_data = 0;
  logic r_fp = 0, r_en = 0;
  logic t1_mode = 0, fbit_pass = 0, min_delay = 0;
  logic [7:0] r_data;
  logic slip_evt, slip_del;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] rbuf [32];
  logic seen_slip, seen_del;
  logic [7:0] wbase = 8'h10;

  // row: [15:14] frames written, [13] idle frame, [12] slip, [11] held slip kind, [7:0] base
  localparam logic [15:0] TBL [9] = '{16'h2000, 16'h4010, 16'h4020, 16'h1020,
                                      16'h9840, 16'h4850, 16'hD880, 16'h1080, 16'h4090};

  rx_elastic_store i_rx_elastic_store (
    .wclk(wclk), .wrst(wrst), .w_en(w_en), .w_sof(w_sof), .w_fbit(w_fbit),
    .w_data(w_data), .rclk(rclk), .rrst(rrst), .r_fp(r_fp), .r_en(r_en),
    .t1_mode(t1_mode), .fbit_pass(fbit_pass), .min_delay(min_delay),
    .r_data(r_data), .slip_evt(slip_evt), .slip_del(slip_del));

  always #5 rclk = ~rclk;
  initial begin #2; forever #7 wclk = ~wclk; end

  always @(posedge rclk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_frame(int n, logic [7:0] base, logic fb);
    for (int c = 0; c < n; c++) begin
      @(negedge wclk);
      w_en = 1; w_sof = (c == 0); w_fbit = fb; w_data = base + 8'(c);
    end
    @(negedge wclk);
    w_en = 0; w_sof = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic read_frame();
    for (int s = 0; s < 32; s++) begin
      @(negedge rclk);
      if (s > 0) rbuf[s-1] = r_data;
      if (s == 1) begin seen_slip = slip_evt; seen_del = slip_del; end
      r_en = 1; r_fp = (s == 0);
    end
    @(negedge rclk);
    rbuf[31] = r_data;
    r_en = 0; r_fp = 0;
  endtask

  function automatic logic [7:0] exp_byte(logic idle, logic t1, logic fp, logic fb,
                                          logic [7:0] base, int s);
    if (idle) return 8'hFF;
    if (!t1) return base + 8'(s);
    if (s == 0 && fp) return {fb, 7'h7F};
    if (s % 4 == 0) return 8'hFF;
    return base + 8'(s - s / 4 - 1);
  endfunction

  task automatic check_frame(string req, int n, logic idle, logic t1, logic fp,
                             logic fb, logic [7:0] base);
    int bad = 0, bs = 0;
    logic [7:0] e, a;
    for (int s = n - 1; s >= 0; s--) begin
      if (rbuf[s] !== exp_byte(idle, t1, fp, fb, base, s)) begin bad++; bs = s; end
    end
    e = exp_byte(idle, t1, fp, fb, base, bs);
    a = rbuf[bs];
    check(req, bad == 0, int'(a), int'(e));
  endtask

  initial begin
    repeat (4) @(negedge rclk);
    wrst = 0; rrst = 0;
    @(negedge rclk);
    // R9: reset state
    check("R9 reset r_data", r_data == 8'hFF, r_data, 8'hFF);
    check("R9 reset slip", {slip_evt, slip_del} == 2'b00, {slip_evt, slip_del}, 0);

    // vector table in 32-channel mode: R1, R2, R3, R4, R5
    for (int i = 0; i < 9; i++) begin
      logic [15:0] row;
      row = TBL[i];
      for (int k = 0; k < int'(row[15:14]); k++) begin
        write_frame(32, wbase, 1'b0);
        wbase = wbase + 8'h10;
      end
      settle();
      fbit_pass = row[0];  // R1: fbit_pass has no effect in 32-channel mode
      read_frame();
      check_frame(row[13] ? "R5 unprimed data" : (row[12] ? (row[11] ? "R3 delete data" : "R2 repeat data") : "R1 frame data"),
                  32, row[13], 1'b0, 1'b0, 1'b0, row[7:0]);
      check(row[12] ? "R4 slip pulse" : "R5 R1 no slip", seen_slip == row[12], seen_slip, row[12]);
      check("R4 slip kind held", seen_del == row[11], seen_del, row[11]);
      @(negedge rclk);
      check("R4 pulse one cycle", slip_evt == 1'b0, slip_evt, 0);
    end
    fbit_pass = 0;

    // R6 R7: 24-channel mapping and F-bit
    t1_mode = 1;
    write_frame(24, 8'hA0, 1'b0); settle();
    fbit_pass = 1; read_frame();
    check_frame("R7 fbit 0 in slot 0", 32, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA0);
    write_frame(24, 8'hB0, 1'b1); settle();
    read_frame();
    check_frame("R7 fbit 1 in slot 0", 32, 1'b0, 1'b1, 1'b1, 1'b1, 8'hB0);
    write_frame(24, 8'hC0, 1'b0); settle();
    fbit_pass = 0; read_frame();
    check_frame("R6 idle slots and channel map", 32, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC0);
    check("R6 no slip", seen_slip == 1'b0, seen_slip, 0);
    t1_mode = 0;

    // R8: minimum delay reads the frame in progress
    write_frame(32, 8'h40, 1'b0);
    write_frame(8, 8'hD0, 1'b0);
    settle();
    min_delay = 1; read_frame(); min_delay = 0;
    check_frame("R8 bank in progress", 8, 1'b0, 1'b0, 1'b0, 1'b0, 8'hD0);
    check("R8 no slip", seen_slip == 1'b0, seen_slip, 0);

    // R9: reset mid-run, then R5 and R1 again from a clean state
    @(negedge rclk); rrst = 1;
    @(negedge wclk); wrst = 1;
    repeat (3) @(negedge wclk);
    wrst = 0;
    @(negedge rclk); rrst = 0;
    @(negedge rclk);
    check("R9 reset r_data again", r_data == 8'hFF, r_data, 8'hFF);
    check("R9 reset slip kind", slip_del == 1'b0, slip_del, 0);
    settle(); read_frame();
    check_frame("R5 unprimed after reset", 32, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R5 no slip after reset", seen_slip == 1'b0, seen_slip, 0);
    write_frame(32, 8'hE0, 1'b0); settle(); read_frame();
    check_frame("R1 frame after reset", 32, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule